// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Register

This block is one shared control register for a four-processor system. Any processor can write it to signal an interrupt to another processor, or to drop one that it has received. A processor also writes it to acknowledge its periodic timer interrupt. A tick from an external timer marks a timer interrupt as pending for every processor at once. Each processor has two level outputs, one for the inter-processor interrupt and one for the timer interrupt, and each output follows its pending bit in the register.

One write can carry several kinds of field. Request bits post an interrupt to a processor when written with 1. Pending bits clear an interrupt when written with 1. Timer bits are set by hardware and cleared by a written 1. One bit only acknowledges a missing-memory error and is otherwise ignored. A write that sets none of these fields is unsupported and raises an error pulse. A read returns the stored state, with the two low bits replaced by the id of the processor that reads.

Top module: `cpu_signal_reg`

## Requirements
- R1: While reset is asserted and after it is released, `ipiIrq`, `timerIrq` and `wrErr` are zero and the register holds no pending bit.
- R2: `rdData` bits 1:0 equal `rdCpu` in the same cycle. Bits 7:4 carry the timer flags of processors 0 to 3 and bits 11:8 carry the pending inter-processor bits of processors 0 to 3. Every other bit reads 0.
- R3: A write with bit 12+n set makes pending bit 8+n and `ipiIrq[n]` 1 from the next cycle. If the bit is already 1, it stays 1.
- R4: A write with bit 8+n set clears pending bit 8+n and `ipiIrq[n]` from the next cycle. If the bit is already 0, nothing changes.
- R5: When one write sets both bit 12+n and bit 8+n, the post is applied first and the clear second, so processor n ends up with no pending inter-processor interrupt.
- R6: A cycle with `timerTick` high sets every timer flag (bits 7:4) and every `timerIrq` output from the next cycle.
- R7: A write with bit 4+n set clears timer flag n and `timerIrq[n]` from the next cycle.
- R8: When `timerTick` is high in the same cycle as a write that clears timer flag n, the tick wins and flag n is 1 afterwards.
- R9: A write that sets only bit 28 (with any bits outside 28 and 15:4) is accepted. It changes no state and raises no error.
- R10: A write with bits 15:4 all 0 and bit 28 at 0 is unsupported. It changes no state and raises `wrErr` for exactly the next cycle. `wrErr` is 0 in every cycle that does not follow such a write.
- R11: `ipiIrq[n]` always equals register bit 8+n and `timerIrq[n]` always equals register bit 4+n, as seen through `rdData`.
- R12: A write that combines posts, clears and timer clears for different processors applies all of them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrData | input | 64 | Write data |
| wrCpu | input | 2 | Id of the writing processor (has no effect on the register) |
| timerTick | input | 1 | Periodic timer tick, one cycle per event |
| rdCpu | input | 2 | Id of the reading processor |
| rdData | output | 64 | Read data (combinational) |
| ipiIrq | output | 4 | Inter-processor interrupt level per processor |
| timerIrq | output | 4 | Timer interrupt level per processor |
| wrErr | output | 1 | One-cycle pulse after an unsupported write |

## Verification
A timer tick and a software write that clears a timer flag can arrive in the same cycle. The same is true of a post and a clear of one processor's inter-processor bit inside one write word. The bench provokes both collisions directly, with a tick driven alongside a write to bit 4, and with a write that sets bits 12 and 8 together. It then repeats them many times in random traffic. A behavioural reference model applies the stated orders (tick after the clear, post before the clear) and is compared with every output in every cycle.

// File: rtl/csr_sig_pkg.sv
package csr_sig_pkg;
  localparam int NUM_CPU  = 4;
  localparam int DATA_W   = 64;
  localparam int CPU_ID_W = $clog2(NUM_CPU);
  // field bases inside the register word
  localparam int TMR_LSB  = 4;
  localparam int PEND_LSB = TMR_LSB + NUM_CPU;
  localparam int REQ_LSB  = PEND_LSB + NUM_CPU;
  localparam int ACK_BIT  = 28;

  typedef logic [NUM_CPU-1:0] cpuMask_t;

  typedef struct packed {
    cpuMask_t postMask;
    cpuMask_t clrMask;
    cpuMask_t tmrClrMask;
    logic     tick;
    logic     badWrite;
  } sigStrobe_t;
endpackage

// File: rtl/sig_ctrl.sv
module sig_ctrl
  import csr_sig_pkg::*;
(
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CPU_ID_W-1:0] wrCpu,
  input  logic                timerTick,
  output sigStrobe_t          strobe
);
  cpuMask_t reqField, clrField, tmrField;
  logic     ackField, anyField;
  logic     unusedBits;

  assign reqField = wrData[REQ_LSB +: NUM_CPU];
  assign clrField = wrData[PEND_LSB +: NUM_CPU];
  assign tmrField = wrData[TMR_LSB +: NUM_CPU];
  assign ackField = wrData[ACK_BIT];
  assign anyField = (|reqField) | (|clrField) | (|tmrField) | ackField;

  // bits outside the decoded fields and the writer id do not affect state
  assign unusedBits = ^{wrData[DATA_W-1:ACK_BIT+1], wrData[ACK_BIT-1:REQ_LSB+NUM_CPU],
                        wrData[TMR_LSB-1:0], wrCpu};

  always_comb begin
    strobe            = '0;
    strobe.tick       = timerTick;
    if (wrEn) begin
      strobe.badWrite = ~anyField;
      if (anyField) begin
        strobe.postMask   = reqField;
        strobe.clrMask    = clrField;
        strobe.tmrClrMask = tmrField;
      end
    end
  end
endmodule

// File: rtl/sig_dpath.sv
module sig_dpath
  import csr_sig_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sigStrobe_t          strobe,
  input  logic [CPU_ID_W-1:0] rdCpu,
  output logic [DATA_W-1:0]   rdData,
  output cpuMask_t            ipiIrq,
  output cpuMask_t            timerIrq,
  output logic                wrErr
);
  cpuMask_t pendQ, tmrQ;

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
    logic pendNext, tmrNext;
    always_comb begin
      // post first, then clear
      pendNext = pendQ[n] | strobe.postMask[n];
      if (strobe.clrMask[n]) pendNext = 1'b0;
      // software clear first, then the tick
      tmrNext = tmrQ[n] & ~strobe.tmrClrMask[n];
      if (strobe.tick) tmrNext = 1'b1;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[n] <= 1'b0;
        tmrQ[n]  <= 1'b0;
      end else begin
        pendQ[n] <= pendNext;
        tmrQ[n]  <= tmrNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= strobe.badWrite;
  end

  always_comb begin
    rdData                        = '0;
    rdData[CPU_ID_W-1:0]          = rdCpu;
    rdData[TMR_LSB  +: NUM_CPU]   = tmrQ;
    rdData[PEND_LSB +: NUM_CPU]   = pendQ;
  end

  assign ipiIrq   = pendQ;
  assign timerIrq = tmrQ;
endmodule

// File: rtl/cpu_signal_reg.sv
module cpu_signal_reg
  import csr_sig_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CPU_ID_W-1:0] wrCpu,
  input  logic                timerTick,
  input  logic [CPU_ID_W-1:0] rdCpu,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_CPU-1:0]  ipiIrq,
  output logic [NUM_CPU-1:0]  timerIrq,
  output logic                wrErr
);
  sigStrobe_t strobe;

  sig_ctrl u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .wrCpu(wrCpu),
    .timerTick(timerTick), .strobe(strobe)
  );

  sig_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdCpu(rdCpu),
    .rdData(rdData), .ipiIrq(ipiIrq), .timerIrq(timerIrq), .wrErr(wrErr)
  );
endmodule

// File: rtl/cpu_signal_reg_chk.sv
module cpu_signal_reg_chk
  import csr_sig_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [DATA_W-1:0]   wrData,
  input logic                timerTick,
  input logic [CPU_ID_W-1:0] rdCpu,
  input logic [DATA_W-1:0]   rdData,
  input logic [NUM_CPU-1:0]  ipiIrq,
  input logic [NUM_CPU-1:0]  timerIrq,
  input logic                wrErr
);
  logic [NUM_CPU-1:0] req, clr, tclr, postOnly;
  logic               noField;
  assign req      = wrData[REQ_LSB +: NUM_CPU];
  assign clr      = wrData[PEND_LSB +: NUM_CPU];
  assign tclr     = wrData[TMR_LSB +: NUM_CPU];
  assign postOnly = req & ~clr;
  assign noField  = (wrData[REQ_LSB+NUM_CPU-1:TMR_LSB] == '0) && !wrData[ACK_BIT];

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_zero_R1: assert (ipiIrq == '0 && timerIrq == '0 && !wrErr);
    end
  end

  assert_post_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && postOnly != '0) |=> ((ipiIrq & $past(postOnly)) == $past(postOnly)));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((ipiIrq & $past(clr)) == '0));

  assert_tick_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |=> (timerIrq == '1));

  assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !timerTick) |=> ((timerIrq & $past(tclr)) == '0));

  assert_bad_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && noField) |=> wrErr);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && noField) |=> !wrErr);

  assert_bad_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && noField && !timerTick) |=> (ipiIrq == $past(ipiIrq) && timerIrq == $past(timerIrq)));

  assert_read_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[CPU_ID_W-1:0] == rdCpu && rdData[DATA_W-1:REQ_LSB] == '0
     && rdData[TMR_LSB-1:CPU_ID_W] == '0));

  assert_mirror_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[PEND_LSB +: NUM_CPU] == ipiIrq && rdData[TMR_LSB +: NUM_CPU] == timerIrq));
endmodule

bind cpu_signal_reg cpu_signal_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .timerTick(timerTick),
  .rdCpu(rdCpu), .rdData(rdData), .ipiIrq(ipiIrq), .timerIrq(timerIrq), .wrErr(wrErr)
);

// File: tb/cpu_signal_reg_tb.sv
module cpu_signal_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [1:0]  wrCpu = '0;
  logic        timerTick = 1'b0;
  logic [1:0]  rdCpu = '0;
  logic [63:0] rdData;
  logic [3:0]  ipiIrq, timerIrq;
  logic        wrErr;

  always #4 clk = ~clk;  // 125 MHz

  cpu_signal_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrCpu(wrCpu),
    .timerTick(timerTick), .rdCpu(rdCpu), .rdData(rdData),
    .ipiIrq(ipiIrq), .timerIrq(timerIrq), .wrErr(wrErr)
  );

  int vecs = 0;
  int miss = 0;
  bit mPend[4];
  bit mTmr[4];
  bit mErr = 0;
  string prevTag = "R1";

  function automatic logic [3:0] pack4(input bit v[4]);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic compare(input string tag);
    logic [63:0] expRd;
    expRd = 64'd0;
    expRd[1:0] = rdCpu;
    for (int i = 0; i < 4; i++) begin
      expRd[4+i] = mTmr[i];
      expRd[8+i] = mPend[i];
    end
    vecs++;
    if (rdData !== expRd || ipiIrq !== pack4(mPend) || timerIrq !== pack4(mTmr) || wrErr !== mErr) begin
      miss++;
      $display("FAIL %s: rdData=%h exp %h ipi=%b exp %b tmr=%b exp %b err=%b exp %b",
               tag, rdData, expRd, ipiIrq, pack4(mPend), timerIrq, pack4(mTmr), wrErr, mErr);
    end
  endtask

  task automatic model(input logic we, input logic [63:0] d, input logic tk);
    bit known;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mPend[i] = 0; mTmr[i] = 0; end
      mErr = 0;
      return;
    end
    known = we && ((d[15:4] != 0) || d[28]);
    mErr = we && !known;
    if (known) begin
      for (int i = 0; i < 4; i++) if (d[12+i]) mPend[i] = 1;
      for (int i = 0; i < 4; i++) if (d[8+i])  mPend[i] = 0;
      for (int i = 0; i < 4; i++) if (d[4+i])  mTmr[i]  = 0;
    end
    if (tk) for (int i = 0; i < 4; i++) mTmr[i] = 1;
  endtask

  task automatic step(input logic we, input logic [63:0] d, input logic tk,
                      input logic [1:0] rc, input string tag);
    @(negedge clk);
    wrEn = we; wrData = d; timerTick = tk; rdCpu = rc; wrCpu = ~rc;
    #1;
    compare(prevTag);
    model(we, d, tk);
    prevTag = tag;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 64'd0, 1'b0, 2'd0, tag);
  endtask

  initial begin
    #(8 * 150000);
    miss++;
    $display("FAIL watchdog: run hung, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mPend[i] = 0; mTmr[i] = 0; end
    repeat (3) idle("R1");
    rstN = 1'b1;
    idle("R1");
    // R2 read id per reader
    for (int c = 0; c < 4; c++) step(1'b0, 64'd0, 1'b0, 2'(c), "R2");
    // R3 post, repeat post, multiple posts
    step(1'b1, 64'h2000, 1'b0, 2'd1, "R3");
    step(1'b1, 64'h2000, 1'b0, 2'd2, "R3");
    step(1'b1, 64'h9000, 1'b0, 2'd3, "R3");
    idle("R11");
    // R4 clear pending and clear of an idle cpu
    step(1'b1, 64'h0200, 1'b0, 2'd0, "R4");
    step(1'b1, 64'h0400, 1'b0, 2'd0, "R4");
    // R5 post and clear of cpu0 together
    step(1'b1, 64'h1100, 1'b0, 2'd0, "R5");
    idle("R5");
    // R6 tick
    step(1'b0, 64'd0, 1'b1, 2'd1, "R6");
    idle("R6");
    // R7 timer clears
    step(1'b1, 64'h0060, 1'b0, 2'd2, "R7");
    idle("R7");
    // R8 tick and timer clear collide
    step(1'b1, 64'h0010, 1'b1, 2'd3, "R8");
    idle("R8");
    // R9 ack bit only, with noise outside the fields
    step(1'b1, 64'hF000_0000_1000_000F, 1'b0, 2'd0, "R9");
    idle("R9");
    // R10 unsupported writes
    step(1'b1, 64'h0000_0000_0000_0003, 1'b0, 2'd0, "R10");
    step(1'b1, 64'h0000_0000_0001_0000, 1'b0, 2'd1, "R10");
    step(1'b1, 64'd0, 1'b1, 2'd2, "R10");
    idle("R10");
    idle("R10");
    // R12 combined write
    step(1'b1, 64'h4180, 1'b0, 2'd1, "R12");
    idle("R12");
    // random traffic with collisions
    for (int k = 0; k < 400; k++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      case ($urandom % 4)
        0: d = d & 64'h0000_0000_0000_FFF0;
        1: d = d & 64'h0000_0000_1000_000F;
        2: d = d & 64'h0000_0000_0000_000F;
        default: ;
      endcase
      step(($urandom % 3) != 0, d, ($urandom % 8) == 0, 2'($urandom), "R12");
    end
    idle("R12");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule